// File: doc/BRIEF.md
# Two-Wire Register Slave with Strap Address

This block is a slave on a two-wire serial control bus (I2C). Through it a host reads and writes a small bank of device registers. The registers differ in width: a one-byte status register, a one-byte control register, a two-byte volume register and a four-byte coefficient word. The coefficient word keeps a signed 3.23 value in its low 26 bits. The status register carries a sticky fault bit. Hardware sets this bit, and only a host write clears it.

The block samples SCL and SDA with the fast system clock and detects the bus conditions. It drives SDA only by pulling it low through an output-enable. The 7-bit device address comes from an address strap, which is read once after reset. A host writes a register by sending the subaddress and then the data bytes. A host reads a register by sending the subaddress, a repeated start and the read address, then clocking the bytes in. After each complete register, the subaddress moves to the next register, so a host can stream several registers in one transfer.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset the control register is 0x00, the volume register is 0x00C0, the coefficient is 0, the fault bit is 0 and SDA is released (sdaOe = 0).
- R2: The 7-bit device address is 0x2A when addrStrap is low and 0x2B when it is high. The address byte sent on the bus is the address shifted left by one, with the R/W bit (write = 0) in bit 0. The strap is sampled on the first clock after reset is released, and later changes to it have no effect until the next reset.
- R3: The slave pulls SDA low in the acknowledge slot after a matching address. After a non-matching address it does not acknowledge, and it keeps SDA released until the next start condition.
- R4: The first byte after a write address is the subaddress. The subaddress map is: 0x00 status (1 byte, fault in bit 0), 0x01 control (1 byte), 0x02 volume (2 bytes), 0x03 coefficient (4 bytes). Every other subaddress is reserved (1 byte). The slave acknowledges every written byte.
- R5: A multi-byte register is sent MSB first. Its output changes only after the last byte of the register arrives. A register write cut short by a stop or a start leaves the register unchanged.
- R6: After the last byte of a register is written or read, the subaddress moves on to the next register.
- R7: A random read is a write of the subaddress, a repeated start, and the read address. The slave then sends the bytes MSB first. An ACK from the master asks for the next byte, and a NACK ends the read.
- R8: The coefficient register keeps only the low 26 bits of the 32-bit word written to it. When read, its top 6 bits return zero.
- R9: A write to a reserved subaddress is acknowledged and changes no register. A read from a reserved subaddress returns 0x00.
- R10: faultIn high sets the fault bit, and the bit stays set after faultIn falls. The only way to clear it is a host write to subaddress 0x00 with bit 0 set. If faultIn is high in the same cycle as that write, the bit stays set.
- R11: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. After a stop, the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Level sensed on the SDA line |
| addrStrap | input | 1 | Selects the low bit of the device address |
| faultIn | input | 1 | Hardware fault indication |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrlReg | output | 8 | Control register |
| volReg | output | 16 | Volume register |
| coefReg | output | 26 | Coefficient, signed 3.23 |
| faultFlag | output | 1 | Sticky fault bit |

## Verification
Each register width is written and then read back with its own value. This shows whether the bytes are assembled MSB first and whether the 26-bit coefficient drops its top bits. One transfer streams across the control and volume registers, and another reads across status, control and volume, which tests the subaddress advance. A volume write that stops after its first byte is compared with a complete one, and the volume output is sampled after the first byte of a complete write; together these separate an atomic commit from a per-byte update. Other patterns use the wrong address, a reserved subaddress, a write of 0 and then a write of 1 to the fault bit, and a second reset with the strap high. These separate acknowledge decisions, ignored writes, sticky clearing and strap sampling.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  localparam logic [7:0] SUB_STATUS = 8'h00;
  localparam logic [7:0] SUB_CTRL   = 8'h01;
  localparam logic [7:0] SUB_VOL    = 8'h02;
  localparam logic [7:0] SUB_COEF   = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_RLOAD
  } busStateT;

  localparam busStateT ST_IGNORE = ST_IDLE;

  typedef struct packed {
    logic       start;
    logic       subWr;
    logic       dataWr;
    logic       rdAdv;
    logic [7:0] byteVal;
  } strobeT;

  function automatic logic [1:0] regLastIdx(input logic [7:0] sub);
    case (sub)
      SUB_VOL:  regLastIdx = 2'd1;
      SUB_COEF: regLastIdx = 2'd3;
      default:  regLastIdx = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cRegPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic       addrStrap,
  input  logic [7:0] rdByte,
  output strobeT     strb,
  output logic       sdaOe
);

  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclS, sclD, sdaS, sdaD;
  logic startSeen, stopSeen, sclRise, sclFall;
  busStateT state;
  logic [3:0] bitCnt;
  logic [7:0] sh;
  logic firstByte, rwBit, strapArmed;
  logic [6:0] devAddr;
  logic byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], scl};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sclD = sclPipe[SYNC_STAGES];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaD = sdaPipe[SYNC_STAGES];
  assign startSeen = sclS && sclD && sdaD && !sdaS;
  assign stopSeen  = sclS && sclD && !sdaD && sdaS;
  assign sclRise   = sclS && !sclD;
  assign sclFall   = !sclS && sclD;

  assign byteDone = !startSeen && !stopSeen && (state == ST_WDATA) && sclRise && (bitCnt == 4'd7);

  always_comb begin
    strb.start   = startSeen;
    strb.subWr   = byteDone && firstByte;
    strb.dataWr  = byteDone && !firstByte;
    strb.byteVal = {sh[6:0], sdaS};
    strb.rdAdv   = sclFall && !startSeen && !stopSeen &&
                   (((state == ST_ADDR_ACK) && sdaOe && rwBit) || (state == ST_RLOAD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      sh         <= '0;
      sdaOe      <= 1'b0;
      firstByte  <= 1'b0;
      rwBit      <= 1'b0;
      strapArmed <= 1'b1;
      devAddr    <= DEV_ADDR_BASE;
    end else begin
      if (strapArmed) begin
        devAddr    <= {DEV_ADDR_BASE[6:1], addrStrap};
        strapArmed <= 1'b0;
      end
      if (startSeen) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (sclRise) begin
            sh     <= {sh[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
            if (bitCnt == 4'd7) begin
              if (sh[6:0] == devAddr) begin
                rwBit <= sdaS;
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            if (!sdaOe) begin
              sdaOe <= 1'b1;
            end else if (rwBit) begin
              sh     <= rdByte;
              sdaOe  <= !rdByte[7];
              bitCnt <= '0;
              state  <= ST_RDATA;
            end else begin
              sdaOe     <= 1'b0;
              bitCnt    <= '0;
              firstByte <= 1'b1;
              state     <= ST_WDATA;
            end
          end
          ST_WDATA: if (sclRise) begin
            sh     <= {sh[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
            if (bitCnt == 4'd7) state <= ST_WACK;
          end
          ST_WACK: if (sclFall) begin
            if (!sdaOe) begin
              sdaOe <= 1'b1;
            end else begin
              sdaOe     <= 1'b0;
              bitCnt    <= '0;
              firstByte <= 1'b0;
              state     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= ST_RACK;
              end else begin
                sdaOe <= !sh[6];
                sh    <= {sh[6:0], 1'b0};
              end
            end
          end
          ST_RACK: if (sclRise) state <= sdaS ? ST_IGNORE : ST_RLOAD;
          ST_RLOAD: if (sclFall) begin
            sh     <= rdByte;
            sdaOe  <= !rdByte[7];
            bitCnt <= '0;
            state  <= ST_RDATA;
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strapArmed |=> $stable(devAddr));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

endmodule

// File: rtl/i2cRegBank.sv
module i2cRegBank
  import i2cRegPkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int VOL_W  = 16,
  parameter int COEF_W = 26,
  parameter logic [VOL_W-1:0] VOL_RESET = 16'h00C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              faultIn,
  output logic [7:0]        rdByte,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [VOL_W-1:0]  volReg,
  output logic [COEF_W-1:0] coefReg,
  output logic              faultFlag
);

  localparam int WORD_W = 32;

  logic [7:0] sub;
  logic [1:0] idx, lastIdx, byteSel;
  logic [WORD_W-9:0] stage;
  logic [WORD_W-1:0] wrWord, regView;
  logic commit, clrReq;

  assign lastIdx = regLastIdx(sub);
  assign wrWord  = {stage, strb.byteVal};
  assign commit  = strb.dataWr && (idx == lastIdx);
  assign clrReq  = strb.dataWr && (sub == SUB_STATUS) && strb.byteVal[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sub   <= '0;
      idx   <= '0;
      stage <= '0;
    end else if (strb.start) begin
      idx <= '0;
    end else if (strb.subWr) begin
      sub <= strb.byteVal;
      idx <= '0;
    end else if (strb.dataWr || strb.rdAdv) begin
      if (strb.dataWr) stage <= {stage[WORD_W-17:0], strb.byteVal};
      if (idx == lastIdx) begin
        idx <= '0;
        sub <= sub + 8'd1;
      end else begin
        idx <= idx + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      volReg    <= VOL_RESET;
      coefReg   <= '0;
      faultFlag <= 1'b0;
    end else begin
      faultFlag <= faultIn || (faultFlag && !clrReq);
      if (commit) begin
        case (sub)
          SUB_CTRL: ctrlReg <= wrWord[CTRL_W-1:0];
          SUB_VOL:  volReg  <= wrWord[VOL_W-1:0];
          SUB_COEF: coefReg <= wrWord[COEF_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sub)
      SUB_STATUS: regView = {{(WORD_W-1){1'b0}}, faultFlag};
      SUB_CTRL:   regView = {{(WORD_W-CTRL_W){1'b0}}, ctrlReg};
      SUB_VOL:    regView = {{(WORD_W-VOL_W){1'b0}}, volReg};
      SUB_COEF:   regView = {{(WORD_W-COEF_W){1'b0}}, coefReg};
      default:    regView = '0;
    endcase
    byteSel = lastIdx - idx;
    rdByte  = regView[{byteSel, 3'b000} +: 8];
  end

  a_r5_vol_atomic: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(volReg) |-> $past(strb.dataWr));

  a_r5_start_realign: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (idx == 2'd0));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clrReq) |=> faultFlag);

  a_r8_coef_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((sub == SUB_COEF) && (idx == 2'd0)) |-> (rdByte[7:2] == 6'd0));

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h2A,
  parameter logic [15:0] VOL_RESET = 16'h00C0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scl,
  input  logic        sdaIn,
  input  logic        addrStrap,
  input  logic        faultIn,
  output logic        sdaOe,
  output logic [7:0]  ctrlReg,
  output logic [15:0] volReg,
  output logic [25:0] coefReg,
  output logic        faultFlag
);

  strobeT strb;
  logic [7:0] rdByte;

  i2cSlaveCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR_BASE(DEV_ADDR_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .rdByte(rdByte), .strb(strb), .sdaOe(sdaOe)
  );

  i2cRegBank #(
    .CTRL_W(8), .VOL_W(16), .COEF_W(26), .VOL_RESET(VOL_RESET)
  ) uBank (
    .clk(clk), .rstN(rstN), .strb(strb), .faultIn(faultIn), .rdByte(rdByte),
    .ctrlReg(ctrlReg), .volReg(volReg), .coefReg(coefReg), .faultFlag(faultFlag)
  );

endmodule

// File: tb/test_i2cRegSlave.sv
module test_i2cRegSlave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic strap = 1'b0;
  logic faultIn = 1'b0;
  logic sdaOe;
  logic busSda;
  logic [7:0] ctrlReg;
  logic [15:0] volReg;
  logic [25:0] coefReg;
  logic faultFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] gotQ[$];

  always #2 clk = ~clk;
  assign busSda = sdaM & !sdaOe;

  i2cRegSlave i_i2cRegSlave (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(busSda), .addrStrap(strap),
    .faultIn(faultIn), .sdaOe(sdaOe), .ctrlReg(ctrlReg), .volReg(volReg),
    .coefReg(coefReg), .faultFlag(faultFlag)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; hold(5);
    sclM = 1'b1; hold(10);
    sdaM = 1'b0; hold(10);
    sclM = 1'b0; hold(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(5);
    sclM = 1'b1; hold(10);
    sdaM = 1'b1; hold(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold(5);
      sclM = 1'b1; hold(10);
      sclM = 1'b0; hold(5);
    end
    sdaM = 1'b1; hold(5);
    sclM = 1'b1; hold(5);
    ack = (busSda == 1'b0);
    hold(5);
    sclM = 1'b0; hold(5);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hold(5);
      sclM = 1'b1; hold(5);
      b[i] = busSda; hold(5);
      sclM = 1'b0; hold(5);
    end
    sdaM = nack; hold(5);
    sclM = 1'b1; hold(10);
    sclM = 1'b0; hold(3);
    sdaM = 1'b1; hold(2);
  endtask

  task automatic writeRegs(input logic [6:0] dev, input logic [7:0] sub,
                           input logic [7:0] data[$], input string req);
    bit ack;
    busStart();
    sendByte({dev, 1'b0}, ack); check(req, 32'(ack), 32'd1);
    sendByte(sub, ack);         check(req, 32'(ack), 32'd1);
    foreach (data[i]) begin
      sendByte(data[i], ack);   check(req, 32'(ack), 32'd1);
    end
    busStop();
  endtask

  task automatic readRegs(input logic [7:0] sub, input logic [7:0] exp[$], input string req);
    bit ack;
    logic [7:0] b;
    foreach (exp[i]) begin
      expQ.push_back(exp[i]);
      tagQ.push_back(req);
    end
    busStart();
    sendByte(8'h54, ack); check(req, 32'(ack), 32'd1);
    sendByte(sub, ack);   check(req, 32'(ack), 32'd1);
    busStart();
    sendByte(8'h55, ack); check(req, 32'(ack), 32'd1);
    for (int i = 0; i < exp.size(); i++) begin
      recvByte(i == exp.size() - 1, b);
      gotQ.push_back(b);
    end
    busStop();
    check("R7 released after NACK", 32'(sdaOe), 32'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0; hold(5);
    rstN = 1'b1; hold(5);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        logic [7:0] got;
        got = gotQ.pop_front();
        nChecks++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL read: actual %h expected none", got);
        end else begin
          logic [7:0] exp;
          string tag;
          exp = expQ.pop_front();
          tag = tagQ.pop_front();
          if (got !== exp) begin
            nFail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    bit ack;
    doReset();
    // R1 reset state
    check("R1 ctrl", 32'(ctrlReg), 32'h00);
    check("R1 vol", 32'(volReg), 32'h00C0);
    check("R1 coef", 32'(coefReg), 32'h0);
    check("R1 fault", 32'(faultFlag), 32'h0);
    check("R1 sda", 32'(sdaOe), 32'h0);

    // R2: strap change after reset is ignored; R4 one-byte write
    strap = 1'b1;
    writeRegs(7'h2A, 8'h01, '{8'h5A}, "R4");
    check("R4 ctrl", 32'(ctrlReg), 32'h5A);

    // R3 non-matching address
    busStart();
    sendByte(8'h56, ack);
    check("R3 nack", 32'(ack), 32'd0);
    sendByte(8'hC3, ack);
    check("R3 released", 32'(ack), 32'd0);
    busStop();
    check("R3 ctrl kept", 32'(ctrlReg), 32'h5A);

    // R5 atomic two-byte volume
    busStart();
    sendByte(8'h54, ack); sendByte(8'h02, ack);
    sendByte(8'h12, ack);
    check("R5 vol mid", 32'(volReg), 32'h00C0);
    sendByte(8'h34, ack);
    busStop();
    check("R5 vol", 32'(volReg), 32'h1234);

    // R5 truncated write discarded
    busStart();
    sendByte(8'h54, ack); sendByte(8'h02, ack); sendByte(8'h77, ack);
    busStop();
    check("R5 partial", 32'(volReg), 32'h1234);

    // R8 coefficient keeps 26 bits
    writeRegs(7'h2A, 8'h03, '{8'hFF, 8'hAB, 8'hCD, 8'hEF}, "R8");
    check("R8 coef", 32'(coefReg), 32'h03ABCDEF);
    readRegs(8'h03, '{8'h03, 8'hAB, 8'hCD, 8'hEF}, "R8 R7 coef read");

    // R6 auto-increment across registers, write and read
    writeRegs(7'h2A, 8'h01, '{8'h11, 8'hBE, 8'hEF}, "R6");
    check("R6 ctrl", 32'(ctrlReg), 32'h11);
    check("R6 vol", 32'(volReg), 32'hBEEF);
    readRegs(8'h00, '{8'h00, 8'h11, 8'hBE, 8'hEF}, "R6 R7 stream read");

    // R9 reserved subaddress
    writeRegs(7'h2A, 8'h20, '{8'h99}, "R9");
    check("R9 ctrl kept", 32'(ctrlReg), 32'h11);
    check("R9 vol kept", 32'(volReg), 32'hBEEF);
    readRegs(8'h20, '{8'h00}, "R9 read zero");

    // R10 sticky fault
    faultIn = 1'b1; hold(3);
    faultIn = 1'b0; hold(3);
    check("R10 set", 32'(faultFlag), 32'd1);
    writeRegs(7'h2A, 8'h00, '{8'h00}, "R10");
    check("R10 kept on bit0=0", 32'(faultFlag), 32'd1);
    readRegs(8'h00, '{8'h01}, "R10 read");
    writeRegs(7'h2A, 8'h00, '{8'h01}, "R10");
    check("R10 cleared", 32'(faultFlag), 32'd0);
    check("R11 sda after stop", 32'(sdaOe), 32'd0);

    // R2 strap high at reset
    strap = 1'b1;
    doReset();
    check("R1 ctrl after reset", 32'(ctrlReg), 32'h00);
    writeRegs(7'h2B, 8'h01, '{8'h3C}, "R2 strap high");
    check("R2 ctrl", 32'(ctrlReg), 32'h3C);
    busStart();
    sendByte(8'h54, ack);
    check("R2 old address nack", 32'(ack), 32'd0);
    busStop();

    hold(20);
    check("R7 all reads seen", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule